// File: doc/BRIEF.md
# DRAM refresh and initialization manager

This block keeps an asynchronous EDO DRAM alive on behalf of an access controller. After reset it stays quiet for a programmable power-up pause. It then runs a counted burst of wake-up cycles, and from then on it issues periodic CAS-before-RAS refresh cycles at a fixed interval. The interval is derived from the device's retention budget, which is 2,048 refreshes per 32 ms, or about one every 15.6 µs. Every duration is a parameter counted in clock cycles.

The block shares the DRAM strobes with the access controller through a request/grant pair. It raises `refReq` whenever it owes a cycle or is in the middle of one, including the trailing precharge. It starts a cycle only on a clock edge where `busGrant` is high, so a memory access in progress is never cut short. Once a cycle has started, it always runs to completion.

Postponed refreshes accumulate in an owed-refresh count. If that count grows beyond a limit, the refresh deadline is considered missed. The block then pulses `overrun`, drops `ready`, discards the count and repeats the whole wake-up burst. `ready` is also low during the pause and the first burst.

Top module: `dram_refresh_mgr`

## Requirements
- R1: From reset release, for exactly `PAUSE_CYC` cycles `refReq` and `ready` stay low and `rasN`/`casN` stay high; `refReq` rises after the `PAUSE_CYC`-th clock edge.
- R2: After the pause exactly `WAKE_COUNT` refresh cycles are issued before `ready` rises, and `ready` rises on the same edge on which the last of them returns `rasN` high.
- R3: In every cycle `casN` goes low exactly `CAS_SETUP_CYC` cycles before `rasN` falls, and `rasN` is never low while `casN` is high.
- R4: `rasN` stays low for exactly `RAS_PULSE_CYC` cycles, and `casN` returns high on the same edge as `rasN`.
- R5: Between two cycles both strobes stay high for at least `RAS_PRE_CYC` cycles.
- R6: `weN` and `oeN` are held high (1) at all times.
- R7: A cycle begins (`casN` falls) only after an edge on which `busGrant` was high. A cycle that has begun completes even if `busGrant` drops.
- R8: `refReq` is high exactly when a wake-up or refresh cycle is owed or a cycle (including its precharge) is in progress.
- R9: In normal operation one refresh becomes owed every `INTERVAL_CYC` cycles, the first one `INTERVAL_CYC` cycles after `ready` rises.
- R10: When an interval expiry and a refresh completion fall on the same edge, the owed-refresh count is left unchanged.
- R11: When the owed count would exceed `DEBT_LIMIT`, the following happen together: `overrun` is high for exactly one cycle, `ready` falls at the same time, the owed count is cleared, and `WAKE_COUNT` cycles are issued again before `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busGrant | input | 1 | Access controller hands the DRAM strobes to this block |
| refReq | output | 1 | Block needs or holds the strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held inactive |
| oeN | output | 1 | Output enable, held inactive |
| ready | output | 1 | DRAM initialised and refresh on schedule |
| overrun | output | 1 | One-cycle flag: refresh deadline missed, wake-up burst restarts |

## Verification
The interval timer can expire on the same edge on which a refresh cycle completes. The owed count must then both grow and shrink, leaving it unchanged. The bench provokes this by withholding the grant until one refresh is owed. It then releases the grant at the single cycle at which the cycle's completion lands on the next timer expiry. It judges the result at the ports, because `refReq` must still be high after the precharge ends. A per-cycle behavioural model also checks every output throughout, including the later overrun and the repeated wake-up burst.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    CY_IDLE   = 2'd0,
    CY_CASPRE = 2'd1,
    CY_RASLOW = 2'd2,
    CY_PRECH  = 2'd3
  } cyc_t;

  typedef enum logic [1:0] {
    DUR_SETUP = 2'd0,
    DUR_PULSE = 2'd1,
    DUR_PRE   = 2'd2
  } dur_t;

  // control -> datapath
  typedef struct packed {
    logic pauseEn;
    logic intRun;
    logic intLoad;
    logic debtClr;
    logic debtDec;
    logic wakeLoad;
    logic wakeDec;
    logic tmrLoad;
    dur_t tmrSel;
  } ctl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic pauseDone;
    logic debtOver;
    logic debtPend;
    logic wakePend;
    logic wakeLast;
    logic tmrZero;
  } dp_status_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int PAUSE_CYC     = 20000,
  parameter int WAKE_COUNT    = 8,
  parameter int INTERVAL_CYC  = 1560,
  parameter int CAS_SETUP_CYC = 2,
  parameter int RAS_PULSE_CYC = 6,
  parameter int RAS_PRE_CYC   = 4,
  parameter int DEBT_LIMIT    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t strobes,
  output dp_status_t  status
);

  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam int DW = $clog2(DEBT_LIMIT + 2);
  localparam int WW = $clog2(WAKE_COUNT + 1);
  localparam int MAX_A = (CAS_SETUP_CYC > RAS_PULSE_CYC) ? CAS_SETUP_CYC : RAS_PULSE_CYC;
  localparam int MAX_DUR = (MAX_A > RAS_PRE_CYC) ? MAX_A : RAS_PRE_CYC;
  localparam int TW = $clog2(MAX_DUR + 1);

  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] INT_LAST   = IW'(INTERVAL_CYC - 1);
  localparam logic [WW-1:0] WAKE_INIT  = WW'(WAKE_COUNT);
  localparam logic [DW:0]   DEBT_LIM_W = (DW + 1)'(DEBT_LIMIT);
  localparam logic [TW-1:0] SETUP_LAST = TW'(CAS_SETUP_CYC - 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(RAS_PULSE_CYC - 1);
  localparam logic [TW-1:0] PRE_LAST   = TW'(RAS_PRE_CYC - 1);

  logic [PW-1:0] pauseCnt;
  logic [IW-1:0] intCnt;
  logic [DW-1:0] debtQ;
  logic [DW:0]   debtNext;
  logic [WW-1:0] wakeLeft;
  logic [TW-1:0] tmrQ;
  logic [TW-1:0] tmrInit;
  logic          tick;

  // power-up pause
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     pauseCnt <= '0;
    else if (strobes.pauseEn && pauseCnt != PAUSE_LAST) pauseCnt <= pauseCnt + PW'(1);
  end

  // refresh interval down-counter
  assign tick = strobes.intRun && (intCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                intCnt <= '0;
    else if (strobes.intLoad) intCnt <= INT_LAST;
    else if (tick)            intCnt <= INT_LAST;
    else if (strobes.intRun)  intCnt <= intCnt - IW'(1);
  end

  // owed refreshes: a tick and a completion on the same edge cancel
  assign debtNext = {1'b0, debtQ} + {{DW{1'b0}}, tick} - {{DW{1'b0}}, strobes.debtDec};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                debtQ <= '0;
    else if (strobes.debtClr) debtQ <= '0;
    else                      debtQ <= debtNext[DW-1:0];
  end

  // wake-up cycles still to issue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wakeLeft <= '0;
    else if (strobes.wakeLoad) wakeLeft <= WAKE_INIT;
    else if (strobes.wakeDec)  wakeLeft <= wakeLeft - WW'(1);
  end

  // strobe phase duration timer
  always_comb begin
    case (strobes.tmrSel)
      DUR_SETUP: tmrInit = SETUP_LAST;
      DUR_PULSE: tmrInit = PULSE_LAST;
      default:   tmrInit = PRE_LAST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tmrQ <= '0;
    else if (strobes.tmrLoad) tmrQ <= tmrInit;
    else if (tmrQ != '0)      tmrQ <= tmrQ - TW'(1);
  end

  assign status.pauseDone = (pauseCnt == PAUSE_LAST);
  assign status.debtOver  = (debtNext > DEBT_LIM_W);
  assign status.debtPend  = (debtQ != '0);
  assign status.wakePend  = (wakeLeft != '0);
  assign status.wakeLast  = (wakeLeft == WW'(1));
  assign status.tmrZero   = (tmrQ == '0);

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busGrant,
  input  dp_status_t  status,
  output ctl_strobe_t strobes,
  output logic        refReq,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic        oeN,
  output logic        ready,
  output logic        overrun
);

  phase_t phaseQ, phaseNext;
  cyc_t   cycQ, cycNext;
  logic   overrunQ;

  logic done, pending, start, overrunHit, wakeFinish;

  assign done       = (cycQ == CY_RASLOW) && status.tmrZero;
  assign pending    = ((phaseQ == PH_WAKE) && status.wakePend) ||
                      ((phaseQ == PH_RUN) && status.debtPend);
  assign start      = (cycQ == CY_IDLE) && pending && busGrant;
  assign overrunHit = (phaseQ == PH_RUN) && status.debtOver;
  assign wakeFinish = (phaseQ == PH_WAKE) && done && status.wakeLast;

  always_comb begin
    strobes          = '0;
    strobes.pauseEn  = (phaseQ == PH_PAUSE);
    strobes.intRun   = (phaseQ == PH_RUN);
    strobes.intLoad  = wakeFinish;
    strobes.debtClr  = overrunHit || wakeFinish;
    strobes.debtDec  = (phaseQ == PH_RUN) && done;
    strobes.wakeLoad = ((phaseQ == PH_PAUSE) && status.pauseDone) || overrunHit;
    strobes.wakeDec  = (phaseQ == PH_WAKE) && done;
    strobes.tmrSel   = DUR_SETUP;
    if (start) begin
      strobes.tmrLoad = 1'b1;
      strobes.tmrSel  = DUR_SETUP;
    end else if ((cycQ == CY_CASPRE) && status.tmrZero) begin
      strobes.tmrLoad = 1'b1;
      strobes.tmrSel  = DUR_PULSE;
    end else if (done) begin
      strobes.tmrLoad = 1'b1;
      strobes.tmrSel  = DUR_PRE;
    end
  end

  always_comb begin
    phaseNext = phaseQ;
    case (phaseQ)
      PH_PAUSE: if (status.pauseDone) phaseNext = PH_WAKE;
      PH_WAKE:  if (wakeFinish)       phaseNext = PH_RUN;
      PH_RUN:   if (overrunHit)       phaseNext = PH_WAKE;
      default:                        phaseNext = PH_PAUSE;
    endcase
  end

  always_comb begin
    cycNext = cycQ;
    case (cycQ)
      CY_IDLE:   if (start)          cycNext = CY_CASPRE;
      CY_CASPRE: if (status.tmrZero) cycNext = CY_RASLOW;
      CY_RASLOW: if (status.tmrZero) cycNext = CY_PRECH;
      default:   if (status.tmrZero) cycNext = CY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= PH_PAUSE;
      cycQ     <= CY_IDLE;
      overrunQ <= 1'b0;
    end else begin
      phaseQ   <= phaseNext;
      cycQ     <= cycNext;
      overrunQ <= overrunHit;
    end
  end

  assign casN    = !((cycQ == CY_CASPRE) || (cycQ == CY_RASLOW));
  assign rasN    = (cycQ != CY_RASLOW);
  assign weN     = 1'b1;
  assign oeN     = 1'b1;
  assign refReq  = pending || (cycQ != CY_IDLE);
  assign ready   = (phaseQ == PH_RUN);
  assign overrun = overrunQ;

endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr
  import refresh_pkg::*;
#(
  parameter int PAUSE_CYC     = 20000,
  parameter int WAKE_COUNT    = 8,
  parameter int INTERVAL_CYC  = 1560,
  parameter int CAS_SETUP_CYC = 2,
  parameter int RAS_PULSE_CYC = 6,
  parameter int RAS_PRE_CYC   = 4,
  parameter int DEBT_LIMIT    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic oeN,
  output logic ready,
  output logic overrun
);

  ctl_strobe_t strobes;
  dp_status_t  status;

  refresh_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .status   (status),
    .strobes  (strobes),
    .refReq   (refReq),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .oeN      (oeN),
    .ready    (ready),
    .overrun  (overrun)
  );

  refresh_dp #(
    .PAUSE_CYC     (PAUSE_CYC),
    .WAKE_COUNT    (WAKE_COUNT),
    .INTERVAL_CYC  (INTERVAL_CYC),
    .CAS_SETUP_CYC (CAS_SETUP_CYC),
    .RAS_PULSE_CYC (RAS_PULSE_CYC),
    .RAS_PRE_CYC   (RAS_PRE_CYC),
    .DEBT_LIMIT    (DEBT_LIMIT)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .status  (status)
  );

endmodule

// File: rtl/refresh_mgr_chk.sv
module refresh_mgr_chk #(
  parameter int RAS_PULSE_CYC = 6,
  parameter int RAS_PRE_CYC   = 4
) (
  input logic clk,
  input logic rstN,
  input logic busGrant,
  input logic refReq,
  input logic rasN,
  input logic casN,
  input logic ready,
  input logic overrun
);

  logic [15:0] rasLowCnt;
  logic [15:0] bothHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rasLowCnt <= '0;
    else if (rasN)              rasLowCnt <= '0;
    else if (rasLowCnt != '1)   rasLowCnt <= rasLowCnt + 16'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   bothHighCnt <= 16'(RAS_PRE_CYC);
    else if (!casN || !rasN)     bothHighCnt <= '0;
    else if (bothHighCnt != '1)  bothHighCnt <= bothHighCnt + 16'd1;
  end

  // R3
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && !$past(casN)));

  // R3
  ras_under_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);

  // R4
  ras_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (rasLowCnt == 16'(RAS_PULSE_CYC)));

  // R4
  cas_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN));

  // R5
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> (bothHighCnt >= 16'(RAS_PRE_CYC)));

  // R7
  grant_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(busGrant));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> refReq);

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $rose(rasN));

  // R11
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> (!ready && $past(ready)));

  // R11
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> !overrun);

endmodule

bind dram_refresh_mgr refresh_mgr_chk #(
  .RAS_PULSE_CYC (RAS_PULSE_CYC),
  .RAS_PRE_CYC   (RAS_PRE_CYC)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busGrant (busGrant),
  .refReq   (refReq),
  .rasN     (rasN),
  .casN     (casN),
  .ready    (ready),
  .overrun  (overrun)
);

// File: tb/dram_refresh_mgr_tb_top.sv
module dram_refresh_mgr_tb_top;

  localparam int P_PAUSE = 20;
  localparam int P_WAKE  = 8;
  localparam int P_INT   = 40;
  localparam int P_SETUP = 2;
  localparam int P_PULSE = 4;
  localparam int P_PRE   = 3;
  localparam int P_LIMIT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGrant = 1'b1;
  logic refReq, rasN, casN, weN, oeN, ready, overrun;

  always #5 clk = ~clk;

  dram_refresh_mgr #(
    .PAUSE_CYC     (P_PAUSE),
    .WAKE_COUNT    (P_WAKE),
    .INTERVAL_CYC  (P_INT),
    .CAS_SETUP_CYC (P_SETUP),
    .RAS_PULSE_CYC (P_PULSE),
    .RAS_PRE_CYC   (P_PRE),
    .DEBT_LIMIT    (P_LIMIT)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .refReq   (refReq),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .oeN      (oeN),
    .ready    (ready),
    .overrun  (overrun)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycNum = 0;
  bit checking = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 pause, 1 wake, 2 run ; cyc: 0 idle, 1 cas-only, 2 ras+cas, 3 precharge
  int mPh = 0, mCyc = 0, mCnt = 0, mPause = 0, mInt = 0, mDebt = 0, mWake = 0;
  bit mOver = 0;
  bit grantAtEdge = 0;

  always @(posedge clk) begin
    cycNum++;
    grantAtEdge <= busGrant;
    if (!rstN) begin
      mPh = 0; mCyc = 0; mCnt = 0; mPause = 0; mInt = 0; mDebt = 0; mWake = 0; mOver = 0;
    end else begin
      bit dn, pd, tk, ov;
      int d;
      dn = (mCyc == 2) && (mCnt == 0);
      pd = ((mPh == 1) && (mWake > 0)) || ((mPh == 2) && (mDebt > 0));
      tk = (mPh == 2) && (mInt == 0);
      ov = 0;
      case (mCyc)
        0: if (pd && busGrant) begin mCyc = 1; mCnt = P_SETUP - 1; end
        1: if (mCnt == 0) begin mCyc = 2; mCnt = P_PULSE - 1; end else mCnt--;
        2: if (mCnt == 0) begin mCyc = 3; mCnt = P_PRE - 1; end else mCnt--;
        default: if (mCnt == 0) mCyc = 0; else mCnt--;
      endcase
      case (mPh)
        0: if (mPause == P_PAUSE - 1) begin mPh = 1; mWake = P_WAKE; end else mPause++;
        1: if (dn) begin
             mWake--;
             if (mWake == 0) begin mPh = 2; mInt = P_INT - 1; mDebt = 0; end
           end
        default: begin
          if (tk) mInt = P_INT - 1; else mInt--;
          d = mDebt + (tk ? 1 : 0) - (dn ? 1 : 0);
          if (d > P_LIMIT) begin mPh = 1; mWake = P_WAKE; mDebt = 0; ov = 1; end
          else mDebt = d;
        end
      endcase
      mOver = ov;
    end
  end

  // ---------------- per-cycle comparison and strobe trackers ----------------
  bit prevRas = 1, prevCas = 1;
  int casLowRun = 0, rasLowRun = 0, highRun = 100, rasFalls = 0;

  always @(negedge clk) begin
    if (checking) begin
      bit eCas, eRas, eReq, eRdy;
      eCas = !((mCyc == 1) || (mCyc == 2));
      eRas = (mCyc != 2);
      eReq = ((mPh == 1) && (mWake > 0)) || ((mPh == 2) && (mDebt > 0)) || (mCyc != 0);
      eRdy = (mPh == 2);
      chk(casN == eCas, "R7 casN vs model", int'(casN), int'(eCas));
      chk(rasN == eRas, "R4 rasN vs model", int'(rasN), int'(eRas));
      chk(refReq == eReq, "R8 refReq vs model", int'(refReq), int'(eReq));
      chk(ready == eRdy, "R2 ready vs model", int'(ready), int'(eRdy));
      chk(overrun == mOver, "R11 overrun vs model", int'(overrun), int'(mOver));
      chk(weN && oeN, "R6 weN/oeN held high", int'({weN, oeN}), 3);
      if (prevRas && !rasN) begin
        chk(casLowRun == P_SETUP, "R3 cas lead before ras", casLowRun, P_SETUP);
        rasFalls++;
      end
      if (!prevRas && rasN) begin
        chk(rasLowRun == P_PULSE, "R4 ras low width", rasLowRun, P_PULSE);
        chk(casN == 1'b1, "R4 cas released with ras", int'(casN), 1);
      end
      if (prevCas && !casN) begin
        chk(highRun >= P_PRE, "R5 precharge length", highRun, P_PRE);
        chk(grantAtEdge == 1'b1, "R7 start needs grant", int'(grantAtEdge), 1);
      end
      casLowRun = casN ? 0 : casLowRun + 1;
      rasLowRun = rasN ? 0 : rasLowRun + 1;
      highRun   = (casN && rasN) ? highRun + 1 : 0;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cycNum, 0);
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    int t0, f0, guard;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checking = 1;
    chk(!ready && !refReq && rasN && casN, "R1 reset state", int'({ready, refReq, rasN, casN}), 3);

    for (int i = 1; i < P_PAUSE; i++) begin
      @(negedge clk);
      chk(!refReq && casN && !ready, "R1 pause quiet", int'(refReq), 0);
    end
    @(negedge clk);
    chk(refReq == 1'b1, "R1 request after pause", int'(refReq), 1);

    f0 = rasFalls;
    guard = 0;
    while (!ready && guard < 2000) begin @(negedge clk); guard++; end
    chk(rasFalls - f0 == P_WAKE, "R2 wake burst length", rasFalls - f0, P_WAKE);

    // R9: first owed refresh one interval after ready
    t0 = cycNum;
    guard = 0;
    while (refReq && guard < 100) begin @(negedge clk); guard++; end
    guard = 0;
    while (!refReq && guard < 200) begin @(negedge clk); guard++; end
    chk(cycNum - t0 == P_INT, "R9 interval to first request", cycNum - t0, P_INT);

    repeat (200) @(negedge clk);

    // R10: align a refresh completion with a timer expiry
    busGrant = 1'b0;
    guard = 0;
    while (!(mDebt >= 1 && mCyc == 0 && mInt == P_SETUP + P_PULSE) && guard < 300) begin
      @(negedge clk); guard++;
    end
    chk(guard < 300, "R10 alignment reached", guard, 0);
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0;
    repeat (P_SETUP + P_PULSE + P_PRE + 2) @(negedge clk);
    chk(refReq && casN && rasN, "R10 owed count kept", int'(refReq), 1);

    // R11: keep starving until the deadline is missed
    guard = 0;
    while (!overrun && guard < 300) begin @(negedge clk); guard++; end
    chk(overrun == 1'b1, "R11 overrun raised", int'(overrun), 1);
    chk(ready == 1'b0, "R11 ready drops", int'(ready), 0);
    @(negedge clk);
    chk(overrun == 1'b0, "R11 one-cycle pulse", int'(overrun), 0);
    repeat (20) @(negedge clk);
    chk(refReq && casN, "R7 no cycle while grant withheld", int'(casN), 1);

    f0 = rasFalls;
    busGrant = 1'b1;
    guard = 0;
    while (!ready && guard < 2000) begin @(negedge clk); guard++; end
    chk(rasFalls - f0 == P_WAKE, "R11 burst repeated", rasFalls - f0, P_WAKE);

    repeat (150) @(negedge clk);
    finish_run();
  end

endmodule